// File: doc/BRIEF.md
# Mailbox Command Frame Receiver

This block takes commands from a host one byte at a time through an 8-bit mailbox register. Each host write raises a pending request. The receiver consumes the pending byte on the next clock, and that consumption drops the request at the same edge. The first byte of a frame is a header. Most headers pack a handler number in the top three bits and a payload size in the low five bits.

After the header, the receiver stores the payload bytes on its own into a frame buffer and counts them down. When the count runs out, it emits a one-cycle completion event carrying the handler number and a processing state. Three reserved header codes use their own rules:
- A bulk-setup code carries a destination address and a byte count. A streaming phase follows it, and in that phase each later byte goes out on an address-tagged output.
- An extended code carries a fixed block of parameters.
- A ready code has no payload and sets a sticky flag.

A busy input holds off all consumption, so a pending byte waits in the mailbox. Software or a downstream dispatcher reads the captured payload through a byte-offset read port.

Top module: `cmd_frame_rx`

## Requirements
- R1: A host write makes `pend_o` read 1 in the following cycle. Consuming a byte makes `pend_o` read 0 in the next cycle, unless a new write lands in the same cycle. In that case `pend_o` stays 1 and the new byte is consumed next.
- R2: A header other than 0xE1, 0xE2 or 0xE3 takes its handler number from bits 7:5 and its payload size from bits 4:0 plus one (1 to 32 bytes). After exactly that many payload bytes, `done_o` pulses with `done_hnd_o` equal to bits 7:5 and `done_state_o` = 0.
- R3: The payload of a standard frame is stored at buffer offsets 0 upward, in arrival order. It can be read combinationally on `rd_data_o` at offset `rd_addr_i`.
- R4: Header 0xE1 takes a 6-byte payload, stored at offsets 32 to 37. After the sixth byte, `done_o` pulses with handler 7 and state 2.
- R5: In the 0xE1 payload, bytes 0 to 3 form a big-endian destination address and bytes 4 to 5 form a big-endian count N. If N is nonzero, the next N bytes each appear on `bulk_data_o`, with `bulk_vld_o` high, one cycle after consumption. Byte k carries address destination+k. With the last byte, `done_o` pulses with handler 7 and state 1. If N is zero, the receiver returns straight to header decode.
- R6: Header 0xE2 takes a 10-byte payload, stored at offsets 40 to 49. After the tenth byte, `done_o` pulses with handler 7 and state 3.
- R7: Header 0xE3 has no payload and produces no completion. It sets `ready_o`, which stays set until reset. The next byte is decoded as a header.
- R8: While `busy_i` is 1, no byte is consumed: `pend_o` stays 1 and no output event occurs.
- R9: Reset clears `pend_o`, `ready_o`, `done_o` and `bulk_vld_o`, and abandons any frame in progress. The next byte is decoded as a header.
- R10: `done_o` is high for a single cycle per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe to the mailbox |
| host_data_i | input | 8 | Byte written by the host |
| busy_i | input | 1 | Holds off consumption of pending bytes |
| pend_o | output | 1 | Mailbox holds an unconsumed byte |
| done_o | output | 1 | One-cycle frame completion pulse |
| done_hnd_o | output | 3 | Handler number of the completed frame |
| done_state_o | output | 2 | Processing state of the completed frame |
| ready_o | output | 1 | Sticky ready flag set by 0xE3 |
| bulk_vld_o | output | 1 | Streaming-phase byte valid |
| bulk_addr_o | output | 32 | Destination address of the streamed byte |
| bulk_data_o | output | 8 | Streamed byte |
| rd_addr_i | input | 6 | Frame buffer read offset |
| rd_data_o | output | 8 | Frame buffer byte at that offset |

## Verification
The bench writes a byte in the same cycle the previous one is consumed. A design that let the consume clear override the write would lose that byte and never complete the frame.

It sends the largest standard payload (32 bytes) and an extended frame. An off-by-one in the countdown would complete early or hang.

It runs a bulk setup with a nonzero count and another with a zero count. A wrong byte order would misroute the stream, and a design that entered streaming on zero would swallow the next header.

It also checks that the ready code and a reset mid-frame both leave the receiver decoding headers, and that busy holds the mailbox untouched.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int BYTE_W          = 8;
  localparam int HND_W           = 3;
  localparam int PROC_W          = 2;
  localparam int BULK_ADDR_BYTES = 4;
  localparam int BULK_CNT_BYTES  = 2;
  localparam int BULK_HDR_BYTES  = BULK_ADDR_BYTES + BULK_CNT_BYTES;
  localparam int EXT_BYTES       = 10;
  localparam int BULK_ADDR_W     = 8 * BULK_ADDR_BYTES;
  localparam int BULK_CNT_W      = 8 * BULK_CNT_BYTES;
  localparam int BULK_SH_W       = 8 * BULK_HDR_BYTES;
  localparam int LEN_W           = 6;

  localparam logic [7:0] CODE_BULK  = 8'hE1;
  localparam logic [7:0] CODE_EXT   = 8'hE2;
  localparam logic [7:0] CODE_READY = 8'hE3;

  localparam int BASE_STD  = 0;
  localparam int BASE_BULK = 32;
  localparam int BASE_EXT  = 40;

  localparam logic [PROC_W-1:0] PROC_STD  = 2'd0;
  localparam logic [PROC_W-1:0] PROC_PH2  = 2'd1;
  localparam logic [PROC_W-1:0] PROC_BULK = 2'd2;
  localparam logic [PROC_W-1:0] PROC_EXT  = 2'd3;

  typedef enum logic [1:0] {HK_STD, HK_BULK, HK_EXT, HK_READY} hdr_kind_e;
  typedef enum logic [1:0] {RX_IDLE, RX_PAY, RX_STREAM} rx_state_e;
endpackage

// File: rtl/cfr_latch.sv
module cfr_latch
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              pend_o
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic              pend_q, pend_d;

  always_comb begin
    data_d = data_q;
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (wr_i) begin
      data_d = wdata_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= data_d;
      pend_q <= pend_d;
    end
  end

  assign data_o = data_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cfr_decode.sv
module cfr_decode
  import cfr_pkg::*;
#(
  parameter int BUF_AW = 6
) (
  input  logic [BYTE_W-1:0] hdr_i,
  output hdr_kind_e         kind_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [BUF_AW-1:0] base_o,
  output logic [PROC_W-1:0] proc_o,
  output logic [HND_W-1:0]  hnd_o
);
  always_comb begin
    hnd_o  = hdr_i[7:5];
    kind_o = HK_STD;
    len_o  = LEN_W'({1'b0, hdr_i[4:0]}) + LEN_W'(1);
    base_o = BUF_AW'(BASE_STD);
    proc_o = PROC_STD;
    unique case (hdr_i)
      CODE_BULK: begin
        kind_o = HK_BULK;
        len_o  = LEN_W'(BULK_HDR_BYTES);
        base_o = BUF_AW'(BASE_BULK);
        proc_o = PROC_BULK;
      end
      CODE_EXT: begin
        kind_o = HK_EXT;
        len_o  = LEN_W'(EXT_BYTES);
        base_o = BUF_AW'(BASE_EXT);
        proc_o = PROC_EXT;
      end
      CODE_READY: begin
        kind_o = HK_READY;
        len_o  = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfr_buffer.sv
module cfr_buffer
  import cfr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cfr_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr_i,
  input  logic [BYTE_W-1:0]      host_data_i,
  input  logic                   busy_i,
  output logic                   pend_o,
  output logic                   done_o,
  output logic [HND_W-1:0]       done_hnd_o,
  output logic [PROC_W-1:0]      done_state_o,
  output logic                   ready_o,
  output logic                   bulk_vld_o,
  output logic [BULK_ADDR_W-1:0] bulk_addr_o,
  output logic [BYTE_W-1:0]      bulk_data_o,
  input  logic [BUF_AW-1:0]      rd_addr_i,
  output logic [BYTE_W-1:0]      rd_data_o
);
  logic [BYTE_W-1:0] mbox_data;
  logic              pend;
  logic              take;

  hdr_kind_e         dec_kind;
  logic [LEN_W-1:0]  dec_len;
  logic [BUF_AW-1:0] dec_base;
  logic [PROC_W-1:0] dec_proc;
  logic [HND_W-1:0]  dec_hnd;

  rx_state_e         st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [BUF_AW-1:0] wptr_q, wptr_d;
  logic [PROC_W-1:0] proc_q, proc_d;
  logic [HND_W-1:0]  hnd_q, hnd_d;
  logic [BULK_SH_W-1:0]   sh_q, sh_d;
  logic [BULK_SH_W-1:0]   sh_full;
  logic [BULK_CNT_W-1:0]  brem_q, brem_d;
  logic [BULK_ADDR_W-1:0] baddr_q, baddr_d;

  logic                   done_q, done_d;
  logic [HND_W-1:0]       dhnd_q, dhnd_d;
  logic [PROC_W-1:0]      dst_q, dst_d;
  logic                   rdy_q, rdy_d;
  logic                   bv_q, bv_d;
  logic [BULK_ADDR_W-1:0] ba_q, ba_d;
  logic [BYTE_W-1:0]      bd_q, bd_d;

  logic                   buf_we;

  assign take = pend & ~busy_i;

  cfr_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (host_wr_i),
    .wdata_i (host_data_i),
    .take_i  (take),
    .data_o  (mbox_data),
    .pend_o  (pend)
  );

  cfr_decode #(.BUF_AW(BUF_AW)) u_decode (
    .hdr_i  (mbox_data),
    .kind_o (dec_kind),
    .len_o  (dec_len),
    .base_o (dec_base),
    .proc_o (dec_proc),
    .hnd_o  (dec_hnd)
  );

  cfr_buffer #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk     (clk),
    .we_i    (buf_we),
    .waddr_i (wptr_q),
    .wdata_i (mbox_data),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign sh_full = {sh_q[BULK_SH_W-BYTE_W-1:0], mbox_data};

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    wptr_d  = wptr_q;
    proc_d  = proc_q;
    hnd_d   = hnd_q;
    sh_d    = sh_q;
    brem_d  = brem_q;
    baddr_d = baddr_q;
    done_d  = 1'b0;
    dhnd_d  = dhnd_q;
    dst_d   = dst_q;
    rdy_d   = rdy_q;
    bv_d    = 1'b0;
    ba_d    = ba_q;
    bd_d    = bd_q;
    buf_we  = 1'b0;
    if (take) begin
      unique case (st_q)
        RX_IDLE: begin
          if (dec_kind == HK_READY) begin
            rdy_d = 1'b1;
          end else begin
            st_d   = RX_PAY;
            rem_d  = dec_len;
            wptr_d = dec_base;
            proc_d = dec_proc;
            hnd_d  = dec_hnd;
          end
        end
        RX_PAY: begin
          buf_we = 1'b1;
          wptr_d = wptr_q + BUF_AW'(1);
          rem_d  = rem_q - LEN_W'(1);
          if (proc_q == PROC_BULK) sh_d = sh_full;
          if (rem_q == LEN_W'(1)) begin
            done_d = 1'b1;
            dhnd_d = hnd_q;
            dst_d  = proc_q;
            st_d   = RX_IDLE;
            if (proc_q == PROC_BULK) begin
              baddr_d = sh_full[BULK_SH_W-1 -: BULK_ADDR_W];
              brem_d  = sh_full[BULK_CNT_W-1:0];
              if (sh_full[BULK_CNT_W-1:0] != '0) st_d = RX_STREAM;
            end
          end
        end
        RX_STREAM: begin
          bv_d    = 1'b1;
          bd_d    = mbox_data;
          ba_d    = baddr_q;
          baddr_d = baddr_q + BULK_ADDR_W'(1);
          brem_d  = brem_q - BULK_CNT_W'(1);
          if (brem_q == BULK_CNT_W'(1)) begin
            done_d = 1'b1;
            dhnd_d = hnd_q;
            dst_d  = PROC_PH2;
            st_d   = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      rem_q   <= '0;
      wptr_q  <= '0;
      proc_q  <= PROC_STD;
      hnd_q   <= '0;
      sh_q    <= '0;
      brem_q  <= '0;
      baddr_q <= '0;
      done_q  <= 1'b0;
      dhnd_q  <= '0;
      dst_q   <= PROC_STD;
      rdy_q   <= 1'b0;
      bv_q    <= 1'b0;
      ba_q    <= '0;
      bd_q    <= '0;
    end else begin
      done_q <= done_d;
      bv_q   <= bv_d;
      if (take) begin
        st_q    <= st_d;
        rem_q   <= rem_d;
        wptr_q  <= wptr_d;
        proc_q  <= proc_d;
        hnd_q   <= hnd_d;
        sh_q    <= sh_d;
        brem_q  <= brem_d;
        baddr_q <= baddr_d;
        dhnd_q  <= dhnd_d;
        dst_q   <= dst_d;
        rdy_q   <= rdy_d;
        ba_q    <= ba_d;
        bd_q    <= bd_d;
      end
    end
  end

  assign pend_o       = pend;
  assign done_o       = done_q;
  assign done_hnd_o   = dhnd_q;
  assign done_state_o = dst_q;
  assign ready_o      = rdy_q;
  assign bulk_vld_o   = bv_q;
  assign bulk_addr_o  = ba_q;
  assign bulk_data_o  = bd_q;
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr_i,
  input logic       busy_i,
  input logic       take_i,
  input logic       pend_o,
  input logic       done_o,
  input logic [2:0] done_hnd_o,
  input logic [1:0] done_state_o,
  input logic       ready_o,
  input logic       bulk_vld_o
);
  // R1
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i |=> pend_o);

  // R1
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !host_wr_i) |=> !pend_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && busy_i) |=> (pend_o && !done_o && !bulk_vld_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R6
  special_hnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_state_o != 2'd0) |-> (done_hnd_o == 3'd7));

  // R5
  stream_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i) |=> !bulk_vld_o);
endmodule

bind cmd_frame_rx cfr_checker u_cfr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_i    (host_wr_i),
  .busy_i       (busy_i),
  .take_i       (take),
  .pend_o       (pend_o),
  .done_o       (done_o),
  .done_hnd_o   (done_hnd_o),
  .done_state_o (done_state_o),
  .ready_o      (ready_o),
  .bulk_vld_o   (bulk_vld_o)
);

// File: tb/cmd_frame_rx_bench.sv
module cmd_frame_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        host_wr_i;
  logic [7:0]  host_data_i;
  logic        busy_i;
  logic        pend_o;
  logic        done_o;
  logic [2:0]  done_hnd_o;
  logic [1:0]  done_state_o;
  logic        ready_o;
  logic        bulk_vld_o;
  logic [31:0] bulk_addr_o;
  logic [7:0]  bulk_data_o;
  logic [5:0]  rd_addr_i;
  logic [7:0]  rd_data_o;

  cmd_frame_rx u_cmd_frame_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_i    (host_wr_i),
    .host_data_i  (host_data_i),
    .busy_i       (busy_i),
    .pend_o       (pend_o),
    .done_o       (done_o),
    .done_hnd_o   (done_hnd_o),
    .done_state_o (done_state_o),
    .ready_o      (ready_o),
    .bulk_vld_o   (bulk_vld_o),
    .bulk_addr_o  (bulk_addr_o),
    .bulk_data_o  (bulk_data_o),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o)
  );

  typedef struct packed {
    logic        is_bulk;
    logic [2:0]  hnd;
    logic [1:0]  st;
    logic [31:0] addr;
    logic [7:0]  data;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk;
  int   n_fail;
  bit   finished;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    host_wr_i   = 1'b1;
    host_data_i = b;
    @(negedge clk);
    host_wr_i   = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_done(input logic [2:0] h, input logic [1:0] s);
    exp_t e;
    e = '0;
    e.hnd = h;
    e.st  = s;
    exp_q.push_back(e);
  endtask

  task automatic push_bulk(input logic [31:0] a, input logic [7:0] d);
    exp_t e;
    e = '0;
    e.is_bulk = 1'b1;
    e.addr = a;
    e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic rd_check(input string req, input int off, input logic [7:0] exp);
    @(negedge clk);
    rd_addr_i = 6'(off);
    #1;
    check(req, 32'(rd_data_o), 32'(exp));
  endtask

  // Monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (bulk_vld_o) begin
        if (exp_q.size() == 0 || !exp_q[0].is_bulk) begin
          n_chk++; n_fail++;
          $display("FAIL R5: unexpected stream byte actual %0h expected none", bulk_data_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R5 stream addr", bulk_addr_o, e.addr);
          check("R5 stream data", 32'(bulk_data_o), 32'(e.data));
        end
      end
      if (done_o) begin
        if (exp_q.size() == 0 || exp_q[0].is_bulk) begin
          n_chk++; n_fail++;
          $display("FAIL R2: unexpected completion actual %0h/%0h expected none", done_hnd_o, done_state_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R2 completion handler", 32'(done_hnd_o), 32'(e.hnd));
          check("R2 completion state", 32'(done_state_o), 32'(e.st));
        end
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; host_wr_i = 1'b0; host_data_i = '0; busy_i = 1'b0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pend", 32'(pend_o), 0);
    check("R9 done", 32'(done_o), 0);
    check("R9 ready", 32'(ready_o), 0);
    check("R9 stream", 32'(bulk_vld_o), 0);
    rst_n = 1'b1;

    // R1 pending visible after write, cleared after consume
    @(negedge clk);
    host_wr_i = 1'b1; host_data_i = 8'h02;
    @(negedge clk);
    host_wr_i = 1'b0;
    check("R1 pend after write", 32'(pend_o), 1);
    @(negedge clk);
    check("R1 pend after consume", 32'(pend_o), 0);
    // R2 R3 handler 0, three bytes
    push_done(3'd0, 2'd0);
    send(8'h11); send(8'h22); send(8'h33);
    rd_check("R3 off0", 0, 8'h11);
    rd_check("R3 off2", 2, 8'h33);

    // R2 largest payload 32 bytes, handler 3
    send(8'h7F);
    push_done(3'd3, 2'd0);
    for (int i = 0; i < 32; i++) send(8'(i * 3 + 1));
    rd_check("R3 off31", 31, 8'(31 * 3 + 1));

    // R2 handler 5, one byte; 0xE0 stays standard (handler 7)
    send(8'hA0); push_done(3'd5, 2'd0); send(8'h5A);
    send(8'hE0); push_done(3'd7, 2'd0); send(8'h6B);

    // R6 extended frame
    send(8'hE2);
    push_done(3'd7, 2'd3);
    for (int i = 0; i < 10; i++) send(8'(8'h40 + i));
    rd_check("R6 off40", 40, 8'h40);
    rd_check("R6 off49", 49, 8'h49);

    // R4 R5 bulk setup, address 0x00010010, count 3
    send(8'hE1);
    send(8'h00); send(8'h01); send(8'h00); send(8'h10);
    send(8'h00);
    push_done(3'd7, 2'd2);
    send(8'h03);
    rd_check("R4 off32", 32, 8'h00);
    rd_check("R4 off35", 35, 8'h10);
    rd_check("R4 off37", 37, 8'h03);
    for (int i = 0; i < 3; i++) begin
      push_bulk(32'h0001_0010 + 32'(i), 8'(8'hC0 + i));
      if (i == 2) push_done(3'd7, 2'd1);
      send(8'(8'hC0 + i));
    end

    // R5 zero count returns to header decode
    send(8'hE1);
    for (int i = 0; i < 5; i++) send(8'h00);
    push_done(3'd7, 2'd2);
    send(8'h00);
    send(8'h00); push_done(3'd0, 2'd0); send(8'h99);

    // R7 ready code
    check("R7 ready before", 32'(ready_o), 0);
    send(8'hE3);
    check("R7 ready set", 32'(ready_o), 1);
    send(8'h20); push_done(3'd1, 2'd0); send(8'h77);
    check("R7 ready sticky", 32'(ready_o), 1);

    // R8 busy holds the byte
    busy_i = 1'b1;
    send(8'h00);
    repeat (3) @(negedge clk);
    check("R8 pend held", 32'(pend_o), 1);
    busy_i = 1'b0;
    @(negedge clk);
    check("R8 pend released", 32'(pend_o), 0);
    push_done(3'd0, 2'd0); send(8'h12);

    // R1 write in the same cycle as consume
    push_done(3'd0, 2'd0);
    @(negedge clk); host_wr_i = 1'b1; host_data_i = 8'h00;
    @(negedge clk); host_data_i = 8'hAB;
    @(negedge clk); host_wr_i = 1'b0;
    @(negedge clk);
    check("R1 back-to-back drained", 32'(pend_o), 0);

    // R9 reset mid-frame
    send(8'h1F); send(8'h01); send(8'h02);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 pend after reset", 32'(pend_o), 0);
    check("R9 ready after reset", 32'(ready_o), 0);
    @(negedge clk); rst_n = 1'b1;
    send(8'h00); push_done(3'd0, 2'd0); send(8'h44);

    repeat (4) @(negedge clk);
    check("R10 all events seen", 32'(exp_q.size()), 0);
    summary();
  end
endmodule